// File: doc/BRIEF.md
# Polyphase Scaler Coefficient RAM

This block holds the filter coefficients for a 64-phase polyphase image scaler. It keeps six coefficient tables (horizontal and vertical for luma, chroma and alpha) in each of two banks. The filter datapath reads from one bank while software fills the other. Software loads coefficients through two write strobes. A select write sets the table, phase, tap pair and tap count. Each data write then stores one even-tap and one odd-tap coefficient and advances the write pointer by one pair.

Only phases 0 to 32 are stored. When the datapath asks for a phase above 32, the block reads the stored phase 64 − p and returns its taps in reverse order. A mode bit decides whether chroma filtering uses its own tables or shares the luma tables. A bank swap request takes effect at once when the datapath is idle. If a line is in progress, the swap waits for the next frame-start pulse.

Top module: `psc_coef_ram`

## Requirements
- R1: After a synchronous reset, `bank_cur` is 0, `rd_valid` is 0 and `rd_coef` is all zeros.
- R2: A `sel_wr` pulse loads the write pointer: pair, phase, table and tap-count-minus-one. Each `dat_wr` writes at the pointer and then advances the pair. The last pair is (taps_m1 >> 1). After the last pair, the pair returns to 0 and the phase advances, with phase 32 wrapping to phase 0.
- R3: Within a data write, the even coefficient (tap 2·pair) is stored only when `dat_even_en` is 1. The odd coefficient (tap 2·pair+1) is stored only when `dat_odd_en` is 1. A half whose enable is 0 keeps its old contents.
- R4: When the tap count is odd (taps_m1 even), the odd coefficient of the last pair is stored as zero, whatever value is on `dat_odd`.
- R5: Bits 1:0 of every coefficient returned on `rd_coef` are zero.
- R6: Data writes go to the bank that is not in use (the complement of `bank_cur`). Reads from the bank in use are unaffected by them.
- R7: When `bank_sel` differs from `bank_cur` and `line_busy` is low, `bank_cur` takes the value of `bank_sel` one cycle later.
- R8: While `line_busy` is high, `bank_cur` changes only on a cycle where `frame_start` is high. On that cycle a pending swap takes effect.
- R9: A read issued with `rd_en` returns data two cycles later, with `rd_valid` high for one cycle. Tap k sits at `rd_coef[k*14 +: 14]`. Phases 0 to 32 are returned as stored.
- R10: A read of phase p > 32 returns stored phase 64 − p, with tap k taken from tap 7 − k.
- R11: Table codes are: luma vertical 0, luma horizontal 1, chroma vertical 2, chroma horizontal 3, alpha vertical 4, alpha horizontal 5. When `chroma_sep` is 0, reads of codes 2 and 3 return codes 0 and 1. When `chroma_sep` is 1, codes 2 and 3 return their own tables. Alpha codes are never remapped.
- R12: A read of table code 6 or 7 returns all zeros. A data write whose table code is above 5, or whose phase is above 32, changes no stored coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Load the write pointer from the select fields |
| sel_pair | input | 2 | Starting tap-pair index |
| sel_phase | input | 6 | Starting phase |
| sel_type | input | 3 | Table code |
| sel_taps_m1 | input | 3 | Tap count minus one |
| dat_wr | input | 1 | Write one coefficient pair at the pointer |
| dat_even | input | 14 | Even-tap coefficient |
| dat_even_en | input | 1 | Store the even coefficient |
| dat_odd | input | 14 | Odd-tap coefficient |
| dat_odd_en | input | 1 | Store the odd coefficient |
| bank_sel | input | 1 | Requested bank for the datapath |
| chroma_sep | input | 1 | 1: chroma uses its own tables |
| line_busy | input | 1 | Datapath is inside a line |
| frame_start | input | 1 | Frame-start pulse |
| bank_cur | output | 1 | Bank in use by the datapath |
| rd_en | input | 1 | Datapath read request |
| rd_type | input | 3 | Table code to read |
| rd_phase | input | 6 | Phase to read, 0 to 63 |
| rd_valid | output | 1 | Read data valid |
| rd_coef | output | 112 | All eight taps, tap k at bits k*14 +: 14 |

## Verification
The bench loads tables whose coefficient values have nonzero low bits. It then checks reads at the edge phases 0, 32, 33 and 63. A design that mirrored at the wrong phase, or did not reverse the taps, would return the wrong tap words. Tables are loaded with 4, 5 and 6 taps, so a pointer that wrapped at a fixed four pairs would place coefficients in the wrong phases. A design that kept the odd coefficient of an odd-length filter would show a nonzero tap 5.

Writes are also sent with a table code of 6 and with phase 40, whose addresses would otherwise land on live entries. A design that lacked these guards would visibly corrupt the active bank, or another table, at those entries. Reads of chroma codes are made with the mode bit in both states. A swap is requested while the datapath is mid-line, and must not take effect before the frame-start pulse.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int NUM_FT = 6;
  localparam int FT_W   = 3;

  typedef enum logic [FT_W-1:0] {
    FT_LUMA_V = 3'd0,
    FT_LUMA_H = 3'd1,
    FT_CHR_V  = 3'd2,
    FT_CHR_H  = 3'd3,
    FT_ALP_V  = 3'd4,
    FT_ALP_H  = 3'd5
  } ftype_e;

  // Chroma codes fall back onto the luma tables unless chroma has its own.
  function automatic logic [FT_W-1:0] table_for(logic [FT_W-1:0] req, logic chroma_own);
    if (!chroma_own && (req == FT_CHR_V || req == FT_CHR_H))
      return req - FT_W'(2);
    return req;
  endfunction
endpackage

// File: rtl/psc_wr_ptr.sv
module psc_wr_ptr #(
  parameter int PAIR_W = 2,
  parameter int PH_W   = 6,
  parameter int TAP_W  = 3,
  parameter int FT_W   = 3,
  parameter int HALF   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic [PAIR_W-1:0] sel_pair,
  input  logic [PH_W-1:0]   sel_phase,
  input  logic [FT_W-1:0]   sel_type,
  input  logic [TAP_W-1:0]  sel_taps_m1,
  input  logic              adv,
  output logic [PAIR_W-1:0] pair,
  output logic [PH_W-1:0]   phase,
  output logic [FT_W-1:0]   ftype,
  output logic [TAP_W-1:0]  taps_m1,
  output logic              at_last
);
  assign at_last = (pair == PAIR_W'(taps_m1 >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pair    <= '0;
      phase   <= '0;
      ftype   <= '0;
      taps_m1 <= '0;
    end else if (sel_wr) begin
      pair    <= sel_pair;
      phase   <= sel_phase;
      ftype   <= sel_type;
      taps_m1 <= sel_taps_m1;
    end else if (adv) begin
      if (at_last) begin
        pair  <= '0;
        phase <= (phase >= PH_W'(HALF)) ? '0 : phase + 1'b1;
      end else begin
        pair <= pair + 1'b1;
      end
    end
  end
endmodule

// File: rtl/psc_bank_ctl.sv
module psc_bank_ctl (
  input  logic clk,
  input  logic rst,
  input  logic bank_sel,
  input  logic line_busy,
  input  logic frame_start,
  output logic bank_cur
);
  always_ff @(posedge clk) begin
    if (rst)
      bank_cur <= 1'b0;
    else if (bank_sel != bank_cur && (!line_busy || frame_start))
      bank_cur <= bank_sel;
  end
endmodule

// File: rtl/psc_store.sv
module psc_store #(
  parameter int NTAP  = 8,
  parameter int DW    = 12,
  parameter int DEPTH = 396,
  parameter int AW    = 9
) (
  input  logic              clk,
  input  logic [NTAP-1:0]   we,
  input  logic [AW-1:0]     waddr,
  input  logic [NTAP*DW-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [NTAP*DW-1:0] rdata
);
  // One simple dual-port memory per tap slot, so a pair write and a
  // full-phase read both fit in one cycle.
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we[k]) mem[waddr] <= wdata[k*DW +: DW];
      rd_q <= mem[raddr];
    end
    assign rdata[k*DW +: DW] = rd_q;
  end
endmodule

// File: rtl/psc_coef_ram.sv
module psc_coef_ram
  import psc_pkg::*;
#(
  parameter int TAPS_MAX = 8,
  parameter int COEF_W   = 14,
  parameter int PHASES   = 64,
  localparam int PAIR_W  = $clog2(TAPS_MAX / 2),
  localparam int TAP_W   = $clog2(TAPS_MAX),
  localparam int PH_W    = $clog2(PHASES),
  localparam int OW      = TAPS_MAX * COEF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic [PAIR_W-1:0] sel_pair,
  input  logic [PH_W-1:0]   sel_phase,
  input  logic [FT_W-1:0]   sel_type,
  input  logic [TAP_W-1:0]  sel_taps_m1,
  input  logic              dat_wr,
  input  logic [COEF_W-1:0] dat_even,
  input  logic              dat_even_en,
  input  logic [COEF_W-1:0] dat_odd,
  input  logic              dat_odd_en,
  input  logic              bank_sel,
  input  logic              chroma_sep,
  input  logic              line_busy,
  input  logic              frame_start,
  output logic              bank_cur,
  input  logic              rd_en,
  input  logic [FT_W-1:0]   rd_type,
  input  logic [PH_W-1:0]   rd_phase,
  output logic              rd_valid,
  output logic [OW-1:0]     rd_coef
);
  localparam int HALF   = PHASES / 2;
  localparam int STORED = HALF + 1;
  localparam int DW     = COEF_W - 2;
  localparam int DEPTH  = 2 * NUM_FT * STORED;
  localparam int AW     = $clog2(DEPTH);

  function automatic logic [AW-1:0] addr_of(logic b, logic [FT_W-1:0] t, logic [PH_W-1:0] p);
    return AW'((int'(b) * NUM_FT + int'(t)) * STORED + int'(p));
  endfunction

  // Coefficient LSBs are fixed at zero and never stored.
  logic low_bits_unused;
  assign low_bits_unused = ^{dat_even[1:0], dat_odd[1:0]};

  logic [PAIR_W-1:0] wr_pair;
  logic [PH_W-1:0]   wr_phase;
  logic [FT_W-1:0]   wr_type;
  logic [TAP_W-1:0]  wr_taps_m1;
  logic              wr_last;

  psc_wr_ptr #(.PAIR_W(PAIR_W), .PH_W(PH_W), .TAP_W(TAP_W), .FT_W(FT_W), .HALF(HALF)) u_ptr (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_pair(sel_pair), .sel_phase(sel_phase),
    .sel_type(sel_type), .sel_taps_m1(sel_taps_m1), .adv(dat_wr),
    .pair(wr_pair), .phase(wr_phase), .ftype(wr_type), .taps_m1(wr_taps_m1), .at_last(wr_last)
  );

  psc_bank_ctl u_bank (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .line_busy(line_busy),
    .frame_start(frame_start), .bank_cur(bank_cur)
  );

  // Write side
  logic                  wr_ok, odd_blank;
  logic [TAPS_MAX-1:0]   we;
  logic [TAPS_MAX*DW-1:0] wdata;
  logic [AW-1:0]         waddr;

  assign wr_ok     = dat_wr && (wr_type < FT_W'(NUM_FT)) && (wr_phase <= PH_W'(HALF));
  assign odd_blank = wr_last && !wr_taps_m1[0];
  assign waddr     = addr_of(~bank_cur, wr_type, wr_phase);

  always_comb begin
    for (int k = 0; k < TAPS_MAX; k++) begin
      if (k % 2 == 0) begin
        we[k] = wr_ok && (wr_pair == PAIR_W'(k / 2)) && dat_even_en;
        wdata[k*DW +: DW] = dat_even[COEF_W-1:2];
      end else begin
        we[k] = wr_ok && (wr_pair == PAIR_W'(k / 2)) && dat_odd_en;
        wdata[k*DW +: DW] = odd_blank ? '0 : dat_odd[COEF_W-1:2];
      end
    end
  end

  // Read side
  logic                   rd_ok, rd_mirror;
  logic [FT_W-1:0]        rd_tbl;
  logic [PH_W-1:0]        rd_sp;
  logic [AW-1:0]          raddr;
  logic [TAPS_MAX*DW-1:0] rdata;
  logic                   rv1, mir1, zero1;

  assign rd_ok     = rd_type < FT_W'(NUM_FT);
  assign rd_tbl    = rd_ok ? table_for(rd_type, chroma_sep) : '0;
  assign rd_mirror = rd_phase > PH_W'(HALF);
  assign rd_sp     = rd_mirror ? PH_W'(PHASES - int'(rd_phase)) : rd_phase;
  assign raddr     = addr_of(bank_cur, rd_tbl, rd_sp);

  psc_store #(.NTAP(TAPS_MAX), .DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rv1   <= 1'b0;
      mir1  <= 1'b0;
      zero1 <= 1'b0;
    end else begin
      rv1   <= rd_en;
      mir1  <= rd_mirror;
      zero1 <= !rd_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_coef  <= '0;
    end else begin
      rd_valid <= rv1;
      for (int k = 0; k < TAPS_MAX; k++) begin
        if (zero1)
          rd_coef[k*COEF_W +: COEF_W] <= '0;
        else if (mir1)
          rd_coef[k*COEF_W +: COEF_W] <= {rdata[(TAPS_MAX-1-k)*DW +: DW], 2'b00};
        else
          rd_coef[k*COEF_W +: COEF_W] <= {rdata[k*DW +: DW], 2'b00};
      end
    end
  end
endmodule

// File: rtl/psc_coef_ram_chk.sv
module psc_coef_ram_chk #(
  parameter int TAPS_MAX = 8,
  parameter int COEF_W   = 14,
  localparam int OW      = TAPS_MAX * COEF_W
) (
  input logic          clk,
  input logic          rst,
  input logic          bank_sel,
  input logic          line_busy,
  input logic          frame_start,
  input logic          bank_cur,
  input logic          rd_en,
  input logic [2:0]    rd_type,
  input logic          rd_valid,
  input logic [OW-1:0] rd_coef
);
  function automatic logic [OW-1:0] low_mask();
    logic [OW-1:0] m = '0;
    for (int k = 0; k < TAPS_MAX; k++) m[k*COEF_W +: 2] = 2'b11;
    return m;
  endfunction
  localparam logic [OW-1:0] LOW_MASK = low_mask();

  AST_SWAP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (bank_sel != bank_cur && !line_busy) |=> (bank_cur == $past(bank_sel))); // R7
  AST_SWAP_HELD: assert property (@(posedge clk) disable iff (rst)
    (line_busy && !frame_start) |=> (bank_cur == $past(bank_cur))); // R8
  AST_SWAP_FRAME: assert property (@(posedge clk) disable iff (rst)
    (frame_start && bank_sel != bank_cur) |=> (bank_cur == $past(bank_sel))); // R8
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 rd_valid); // R9
  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ##1 !rd_valid); // R9
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rd_coef & LOW_MASK) == '0)); // R5
  AST_BAD_TYPE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_type > 3'd5) |=> ##1 (rd_coef == '0)); // R12
endmodule

bind psc_coef_ram psc_coef_ram_chk #(.TAPS_MAX(TAPS_MAX), .COEF_W(COEF_W)) u_chk (
  .clk(clk), .rst(rst), .bank_sel(bank_sel), .line_busy(line_busy),
  .frame_start(frame_start), .bank_cur(bank_cur), .rd_en(rd_en), .rd_type(rd_type),
  .rd_valid(rd_valid), .rd_coef(rd_coef)
);

// File: tb/psc_coef_ram_tb.sv
module psc_coef_ram_tb;
  localparam int NT = 8, CW = 14, OW = NT * CW;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_wr = 0, dat_wr = 0, dat_even_en = 0, dat_odd_en = 0;
  logic [1:0] sel_pair = '0;
  logic [5:0] sel_phase = '0, rd_phase = '0;
  logic [2:0] sel_type = '0, sel_taps_m1 = '0, rd_type = '0;
  logic [CW-1:0] dat_even = '0, dat_odd = '0;
  logic bank_sel = 0, chroma_sep = 0, line_busy = 0, frame_start = 0, rd_en = 0;
  logic bank_cur, rd_valid;
  logic [OW-1:0] rd_coef;

  always #4 clk = ~clk;

  psc_coef_ram u_dut (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_pair(sel_pair), .sel_phase(sel_phase),
    .sel_type(sel_type), .sel_taps_m1(sel_taps_m1), .dat_wr(dat_wr), .dat_even(dat_even),
    .dat_even_en(dat_even_en), .dat_odd(dat_odd), .dat_odd_en(dat_odd_en),
    .bank_sel(bank_sel), .chroma_sep(chroma_sep), .line_busy(line_busy),
    .frame_start(frame_start), .bank_cur(bank_cur), .rd_en(rd_en), .rd_type(rd_type),
    .rd_phase(rd_phase), .rd_valid(rd_valid), .rd_coef(rd_coef)
  );

  int checks = 0, errors = 0, mdl_cur = 0;
  logic [CW-3:0] mdl [2][6][33][8];
  logic [OW-1:0] exp_q[$];
  string tag_q[$];
  logic [OW-1:0] mon_e;
  string mon_t;

  function automatic logic [CW-1:0] cval(int seed, int t, int ph, int tap);
    return CW'((seed * 977 + t * 131 + ph * 29 + tap * 7 + 1) & 16'h3fff);
  endfunction

  function automatic logic [OW-1:0] exp_word(int t, int ph, bit csep);
    logic [OW-1:0] e = '0;
    int et, sp;
    if (t > 5) return e;
    et = (!csep && (t == 2 || t == 3)) ? t - 2 : t;
    sp = (ph > 32) ? 64 - ph : ph;
    for (int k = 0; k < NT; k++)
      e[k*CW +: CW] = {mdl[mdl_cur][et][sp][(ph > 32) ? NT - 1 - k : k], 2'b00};
    return e;
  endfunction

  task automatic chk1(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic sel_write(int t, int ph, int pr, int taps_m1);
    sel_type = 3'(t); sel_phase = 6'(ph); sel_pair = 2'(pr); sel_taps_m1 = 3'(taps_m1);
    sel_wr = 1;
    @(negedge clk);
    sel_wr = 0;
  endtask

  task automatic dat_write(logic [CW-1:0] ev, logic [CW-1:0] od, bit een, bit oen);
    dat_even = ev; dat_odd = od; dat_even_en = een; dat_odd_en = oen;
    dat_wr = 1;
    @(negedge clk);
    dat_wr = 0;
  endtask

  task automatic load_table(int t, int taps, int seed);
    int tb = 1 - mdl_cur;
    sel_write(t, 0, 0, taps - 1);
    for (int ph = 0; ph < 33; ph++)
      for (int pr = 0; pr < (taps + 1) / 2; pr++) begin
        logic [CW-1:0] ev = cval(seed, t, ph, 2 * pr);
        logic [CW-1:0] od = cval(seed, t, ph, 2 * pr + 1);
        dat_write(ev, od, 1, 1);
        mdl[tb][t][ph][2*pr]   = ev[CW-1:2];
        mdl[tb][t][ph][2*pr+1] = (2 * pr + 1 < taps) ? od[CW-1:2] : '0;
      end
  endtask

  task automatic read_check(int t, int ph, bit csep, string tag);
    exp_q.push_back(exp_word(t, ph, csep));
    tag_q.push_back(tag);
    rd_type = 3'(t); rd_phase = 6'(ph); chroma_sep = csep; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected rd_valid act=1 exp=0");
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        if (rd_coef !== mon_e) begin
          errors++;
          $display("FAIL %s act=%h exp=%h", mon_t, rd_coef, mon_e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    chk1(bank_cur, 1'b0, "R1 bank_cur after reset");
    chk1(rd_valid, 1'b0, "R1 rd_valid after reset");
    chk1(rd_coef == '0, 1'b1, "R1 rd_coef zero after reset");

    // Fill bank 1 while bank 0 is in use
    load_table(0, 8, 1);
    load_table(1, 8, 2);
    load_table(2, 8, 3);
    load_table(2, 4, 4);   // R2 wrap after two pairs
    load_table(0, 6, 5);   // R2 wrap after three pairs

    bank_sel = 1;
    @(negedge clk);
    chk1(bank_cur, 1'b1, "R7 swap while idle");
    mdl_cur = 1;

    read_check(1, 0, 1, "R9 phase 0");
    read_check(1, 7, 1, "R9 phase 7");
    read_check(1, 32, 1, "R9 phase 32");
    read_check(1, 33, 1, "R10 phase 33");
    read_check(1, 50, 1, "R10 phase 50");
    read_check(1, 63, 1, "R10 phase 63");
    read_check(0, 10, 1, "R2 six-tap load");
    read_check(0, 54, 1, "R10 six-tap mirror");
    read_check(2, 5, 1, "R2 four-tap load");
    read_check(2, 40, 1, "R11 own chroma table");
    read_check(2, 5, 0, "R11 chroma vert uses luma vert");
    read_check(3, 20, 0, "R11 chroma horz uses luma horz");
    read_check(6, 4, 1, "R12 code 6 reads zero");
    read_check(7, 40, 1, "R12 code 7 reads zero");
    repeat (4) @(negedge clk);

    // Fill bank 0 while bank 1 is in use
    load_table(0, 8, 6);
    load_table(1, 8, 7);
    load_table(0, 5, 8);   // R4 odd tap count
    dat_write(14'h1235, 14'h2a7b, 1, 1);  // R2 pointer wrapped to phase 0 pair 0
    mdl[0][0][0][0] = 12'(14'h1235 >> 2);
    mdl[0][0][0][1] = 12'(14'h2a7b >> 2);
    sel_write(0, 3, 0, 4);
    dat_write(14'h0f0f, 14'h3333, 1, 0);  // R3 even only
    mdl[0][0][3][0] = 12'(14'h0f0f >> 2);
    dat_write(14'h1111, 14'h2222, 0, 1);  // R3 odd only (pair 1)
    mdl[0][0][3][3] = 12'(14'h2222 >> 2);
    sel_write(6, 0, 0, 7);
    dat_write(14'h3fff, 14'h3fff, 1, 1);  // R12 ignored, would alias the active bank
    sel_write(0, 40, 0, 7);
    dat_write(14'h3ffe, 14'h3ffd, 1, 1);  // R12 ignored, would alias table 1 phase 7
    read_check(0, 0, 1, "R6 active bank unchanged by writes");
    read_check(1, 7, 1, "R6 active bank table 1 unchanged");
    repeat (4) @(negedge clk);

    // Deferred swap
    bank_sel = 0; line_busy = 1;
    repeat (5) @(negedge clk);
    chk1(bank_cur, 1'b1, "R8 swap held while busy");
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    chk1(bank_cur, 1'b0, "R8 swap at frame start");
    line_busy = 0;
    mdl_cur = 0;

    read_check(0, 0, 1, "R2 phase wrap write");
    read_check(0, 3, 1, "R3 per-half enables");
    read_check(0, 12, 1, "R4 odd last tap zero");
    read_check(0, 52, 1, "R4 R10 mirrored odd taps");
    read_check(1, 7, 1, "R12 out-of-range phase write ignored");
    read_check(1, 57, 1, "R10 mirror of phase 7");
    read_check(1, 20, 0, "R5 low bits zero");
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing reads act=%0d exp=0", exp_q.size());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule